// File: doc/BRIEF.md
# Byte-Syllable Operand-Register Processor Core

This core runs a compact instruction stream in which every instruction is a single 8-bit syllable. Each syllable moves one value between three kinds of storage: a bank of sixteen 64-bit general registers, a pair of 32-bit address registers and a pair of 64-bit operand registers. An ALU syllable combines the two operand registers and writes the result back into one of them. A few syllables are followed by an inline constant of 1, 2, 4 or 8 bytes. The general register with index 15 serves as the program counter, so any move into it is a jump.

Instructions and data share one byte-addressed memory port. A request carries an address, a write flag and a two-bit size code. Read data comes back on the next clock. A small state machine fetches a syllable, decodes it, and where needed spends one extra cycle on the trailing constant or on the loaded word. An illegal syllable stops the core for good and raises `fault`. Only a reset restarts it.

Top module: `syllable_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `fault` is low and the port requests a byte-sized read (`mem_size`=0, `mem_we`=0) at address 0. All general, address and operand registers reset to zero.
- R2: Each syllable is fetched as a one-byte read at the program counter, and the counter then advances by one. A syllable that reads general register 15 (`010axxxx` with xxxx=1111) sees the address of the syllable that follows it.
- R3: `000axxxx` copies the low 32 bits of general register xxxx into address register a. `010axxxx` copies general register xxxx into operand register a. `101axxxx` writes operand register a into general register xxxx. `110axxxx` writes address register a, zero-extended to 64 bits, into general register xxxx.
- R4: Any write to general register 15 makes the next fetch come from the written value.
- R5: `001a00ss` shifts address register a left by ss positions (0 to 3).
- R6: `001a01ss` adds a trailing constant of 2^ss bytes to address register a. The constant is little-endian and sign-extended to 32 bits. The program counter skips the constant bytes.
- R7: `001a11ss` loads operand register a with a trailing little-endian constant of 2^ss bytes, sign-extended to 64 bits. All four sizes are legal.
- R8: `011a0bss` loads operand register a from memory at address register b. `001a10ss` loads address register a from memory at address register 0. The operand is little-endian, 2^ss bytes wide, and sign-extended to the destination width.
- R9: `011a1bss` stores the low 2^ss bytes of operand register a, little-endian, at address register b. Bytes above that width are left unchanged.
- R10: `100affff` writes ALU function ffff of operand 0 and operand 1 into operand register a. The functions are: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right, 8 signed less-than, 9 unsigned less-than, 10 operand 0, 11 operand 1, 12 not operand 0, 13 negate operand 0, 14 low 64 bits of the product, 15 equality. Shift counts use the low 6 bits of operand 1. Compare results are 0 or 1.
- R11: A syllable of the form `111xxxxx`, or `001a01ss`/`001a10ss` with ss=11, is illegal. `fault` rises at the clock edge that ends its decode and then stays high. No memory request is made after that, so none of the syllables that follow takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access width code: 2^code bytes |
| mem_wdata | output | 64 | Store data, little-endian in the low bytes |
| mem_rdata | input | 64 | Read data, due the cycle after a read request |
| fault | output | 1 | Core halted on an illegal syllable |

## Verification
A register-only syllable takes two cycles: the fetch edge, then the decode edge, at which the register update lands. A syllable with a constant or a memory load takes one more edge, at which the value is written. A store updates memory at its decode edge. `fault` rises at the decode edge of the illegal syllable. Every program ends with an illegal stop byte, and the bench samples on falling edges until `fault` is high. Only then does it inspect memory, so every result has already landed. One scenario counts the exact number of edges from reset release to `fault` (eight for its program) to pin down the per-syllable timing.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 64;
  localparam int ALEN = 32;
  localparam int SHW  = $clog2(XLEN);

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_CONST  = 3'd2,
    ST_LOAD   = 3'd3,
    ST_HALT   = 3'd4
  } core_state_t;

  typedef enum logic [3:0] {
    FN_ADD  = 4'd0,  FN_SUB  = 4'd1,  FN_AND  = 4'd2,  FN_OR   = 4'd3,
    FN_XOR  = 4'd4,  FN_SHL  = 4'd5,  FN_SHR  = 4'd6,  FN_SRA  = 4'd7,
    FN_SLT  = 4'd8,  FN_SLTU = 4'd9,  FN_PASA = 4'd10, FN_PASB = 4'd11,
    FN_NOT  = 4'd12, FN_NEG  = 4'd13, FN_MUL  = 4'd14, FN_EQ   = 4'd15
  } alu_fn_t;

  // sign-extend the low 2^sz bytes of raw to full width
  function automatic logic [XLEN-1:0] widen_signed(input logic [XLEN-1:0] raw,
                                                   input logic [1:0] sz);
    case (sz)
      2'd0:    return {{(XLEN-8){raw[7]}}, raw[7:0]};
      2'd1:    return {{(XLEN-16){raw[15]}}, raw[15:0]};
      2'd2:    return {{(XLEN-32){raw[31]}}, raw[31:0]};
      default: return raw;
    endcase
  endfunction

  function automatic logic [3:0] span_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_fn_t fn,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [SHW-1:0] sh;
    sh = b[SHW-1:0];
    case (fn)
      FN_ADD:  return a + b;
      FN_SUB:  return a - b;
      FN_AND:  return a & b;
      FN_OR:   return a | b;
      FN_XOR:  return a ^ b;
      FN_SHL:  return a << sh;
      FN_SHR:  return a >> sh;
      FN_SRA:  return XLEN'($signed(a) >>> sh);
      FN_SLT:  return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      FN_SLTU: return {{(XLEN-1){1'b0}}, (a < b)};
      FN_PASA: return a;
      FN_PASB: return b;
      FN_NOT:  return ~a;
      FN_NEG:  return -a;
      FN_MUL:  return a * b;
      default: return {{(XLEN-1){1'b0}}, (a == b)};
    endcase
  endfunction
endpackage

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic is_cmp;

  assign y      = alu_eval(alu_fn_t'(fn), a, b);
  assign is_cmp = (fn == FN_SLT) || (fn == FN_SLTU) || (fn == FN_EQ);

  always_comb begin
    if (!$isunknown(fn) && !$isunknown(y) && is_cmp) begin
      // R10
      cmp_bool_chk: assert (y[W-1:1] == '0);
    end
  end
endmodule

// File: rtl/sc_gpr_bank.sv
module sc_gpr_bank
  import sc_pkg::*;
#(
  parameter  int NREG  = 16,
  parameter  int W     = XLEN,
  parameter  int AW    = ALEN,
  parameter  int PCIDX = NREG - 1,
  localparam int IW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          adv_en,
  input  logic [3:0]    adv_amt,
  output logic [AW-1:0] pc
);
  logic [NREG-1:0][W-1:0] bank;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] q;
    logic         hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    if (g == PCIDX) begin : g_pc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (hit)    q <= wr_data;
        else if (adv_en) q <= q + W'(adv_amt);
      end
    end else begin : g_gp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
    end
    assign bank[g] = q;
  end

  assign rd_data = bank[rd_idx];
  assign pc      = bank[PCIDX][AW-1:0];

  // R4
  pc_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(PCIDX)) |=> (pc == $past(wr_data[AW-1:0])));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !(wr_en && wr_idx == IW'(PCIDX))) |=>
      (pc == $past(pc) + AW'($past(adv_amt))));
endmodule

// File: rtl/syllable_core.sv
module syllable_core
  import sc_pkg::*;
#(
  parameter  int NGPR = 16,
  localparam int GIW  = $clog2(NGPR),
  localparam int DW   = XLEN,
  localparam int AW   = ALEN
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          fault
);
  core_state_t st, st_nx;
  logic [7:0]    ir;
  logic [AW-1:0] areg [2];
  logic [DW-1:0] oreg [2];

  // syllable fields: live byte while decoding, held copy afterwards
  logic         in_dec;
  logic [7:0]   cur;
  logic [2:0]   grp;
  logic         fa, fb;
  logic [3:0]   fx;
  logic [1:0]   fsub, fss;

  assign in_dec = (st == ST_DECODE);
  assign cur    = in_dec ? mem_rdata[7:0] : ir;
  assign grp    = cur[7:5];
  assign fa     = cur[4];
  assign fx     = cur[3:0];
  assign fsub   = cur[3:2];
  assign fb     = cur[2];
  assign fss    = cur[1:0];

  // decode events, named for the checks
  logic dec_a_from_r, dec_a_shift, dec_const, dec_a_load, dec_o_from_r;
  logic dec_o_load, dec_store, dec_alu, dec_r_from_o, dec_r_from_a;
  logic dec_illegal, dec_load;

  assign dec_a_from_r = in_dec && grp == 3'b000;
  assign dec_a_shift  = in_dec && grp == 3'b001 && fsub == 2'b00;
  assign dec_const    = in_dec && grp == 3'b001 &&
                        ((fsub == 2'b01 && fss != 2'b11) || fsub == 2'b11);
  assign dec_a_load   = in_dec && grp == 3'b001 && fsub == 2'b10 && fss != 2'b11;
  assign dec_o_from_r = in_dec && grp == 3'b010;
  assign dec_o_load   = in_dec && grp == 3'b011 && !cur[3];
  assign dec_store    = in_dec && grp == 3'b011 && cur[3];
  assign dec_alu      = in_dec && grp == 3'b100;
  assign dec_r_from_o = in_dec && grp == 3'b101;
  assign dec_r_from_a = in_dec && grp == 3'b110;
  assign dec_illegal  = in_dec && (grp == 3'b111 ||
                        (grp == 3'b001 && (fsub[1] != fsub[0]) && fss == 2'b11));
  assign dec_load     = dec_a_load || dec_o_load;

  // general register bank with program counter
  logic [DW-1:0] gpr_rd, gpr_wd;
  logic          gpr_we, pc_adv;
  logic [3:0]    pc_amt;
  logic [AW-1:0] pc_q;

  assign gpr_we = dec_r_from_o || dec_r_from_a;
  assign gpr_wd = dec_r_from_o ? oreg[fa] : {{(DW-AW){1'b0}}, areg[fa]};
  assign pc_adv = (st == ST_FETCH) || dec_const;
  assign pc_amt = (st == ST_FETCH) ? 4'd1 : span_bytes(fss);

  sc_gpr_bank #(.NREG(NGPR), .W(DW), .AW(AW)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (GIW'(fx)),
    .rd_data (gpr_rd),
    .wr_en   (gpr_we),
    .wr_idx  (GIW'(fx)),
    .wr_data (gpr_wd),
    .adv_en  (pc_adv),
    .adv_amt (pc_amt),
    .pc      (pc_q)
  );

  logic [DW-1:0] alu_y;
  sc_alu #(.W(DW)) u_alu (
    .fn (fx),
    .a  (oreg[0]),
    .b  (oreg[1]),
    .y  (alu_y)
  );

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_size  = 2'd0;
    mem_wdata = '0;
    if (st == ST_FETCH) begin
      mem_req  = 1'b1;
      mem_addr = pc_q;
    end else if (dec_const) begin
      mem_req  = 1'b1;
      mem_addr = pc_q;
      mem_size = fss;
    end else if (dec_load) begin
      mem_req  = 1'b1;
      mem_addr = dec_a_load ? areg[0] : areg[fb];
      mem_size = fss;
    end else if (dec_store) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = areg[fb];
      mem_size  = fss;
      mem_wdata = oreg[fa];
    end
  end

  // sequencing
  always_comb begin
    st_nx = st;
    case (st)
      ST_FETCH:  st_nx = ST_DECODE;
      ST_DECODE: begin
        if (dec_illegal)    st_nx = ST_HALT;
        else if (dec_const) st_nx = ST_CONST;
        else if (dec_load)  st_nx = ST_LOAD;
        else                st_nx = ST_FETCH;
      end
      ST_CONST:  st_nx = ST_FETCH;
      ST_LOAD:   st_nx = ST_FETCH;
      default:   st_nx = ST_HALT;
    endcase
  end

  logic [DW-1:0] ext_val;
  assign ext_val = widen_signed(mem_rdata, fss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_FETCH;
      ir      <= '0;
      areg[0] <= '0;
      areg[1] <= '0;
      oreg[0] <= '0;
      oreg[1] <= '0;
    end else begin
      st <= st_nx;
      if (in_dec)       ir <= mem_rdata[7:0];
      if (dec_a_from_r) areg[fa] <= gpr_rd[AW-1:0];
      if (dec_a_shift)  areg[fa] <= areg[fa] << fss;
      if (dec_o_from_r) oreg[fa] <= gpr_rd;
      if (dec_alu)      oreg[fa] <= alu_y;
      if (st == ST_CONST) begin
        if (fsub == 2'b01) areg[fa] <= areg[fa] + ext_val[AW-1:0];
        else               oreg[fa] <= ext_val;
      end
      if (st == ST_LOAD) begin
        if (grp == 3'b001) areg[fa] <= ext_val[AW-1:0];
        else               oreg[fa] <= ext_val;
      end
    end
  end

  assign fault = (st == ST_HALT);

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req);

  // R11
  illegal_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_illegal |=> fault);

  // R6
  const_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_const |=> (pc_q == $past(pc_q) + AW'(span_bytes($past(fss)))));

  // R9
  store_in_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && st == ST_DECODE));
endmodule

// File: tb/syllable_core_tb_top.sv
module syllable_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        mem_req, mem_we, fault;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata;
  logic [63:0] rdata = '0;
  logic [7:0]  mem [256];
  int          nchk = 0;
  int          nerr = 0;
  int          wp = 0;
  int          ncyc = 0;
  bit          done = 1'b0;

  always #10ns clk = ~clk;

  syllable_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(rdata), .fault(fault)
  );

  // byte memory, one-cycle read latency
  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      for (int k = 0; k < 8; k++) begin
        if (mem_we) begin
          if (k < (1 << mem_size))
            mem[mem_addr[7:0] + 8'(k)] <= mem_wdata[8*k +: 8];
        end else begin
          rdata[8*k +: 8] <= mem[mem_addr[7:0] + 8'(k)];
        end
      end
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] rd64(input int a);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = mem[(a + k) % 256];
    return v;
  endfunction

  task automatic emit(input logic [7:0] b);
    mem[wp] = b;
    wp++;
  endtask

  task automatic emit_le(input logic [63:0] v, input int n);
    for (int k = 0; k < n; k++) emit(v[8*k +: 8]);
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wp = 0;
  endtask

  task automatic run_to_halt(input string req, input int limit);
    @(negedge clk);
    rst_n = 1'b1;
    ncyc = 0;
    while (!fault && ncyc < limit) begin
      @(negedge clk);
      ncyc++;
    end
    check({req, " reached stop"}, 64'(fault), 64'd1);
  endtask

  function automatic logic [63:0] model_alu(input int f, input logic [63:0] a, input logic [63:0] b);
    int sh;
    sh = int'(b[5:0]);
    case (f)
      0:  return a + b;
      1:  return a + ~b + 64'd1;
      2:  return a & b;
      3:  return a | b;
      4:  return a ^ b;
      5:  return a << sh;
      6:  return a >> sh;
      7:  return (a >> sh) | (a[63] ? ~({64{1'b1}} >> sh) : 64'd0);
      8:  return (a[63] != b[63]) ? 64'(a[63]) : 64'(a < b);
      9:  return 64'(a < b);
      10: return a;
      11: return b;
      12: return a ^ {64{1'b1}};
      13: return ~a + 64'd1;
      14: return a * b;
      default: return (a == b) ? 64'd1 : 64'd0;
    endcase
  endfunction

  // R1: reset state and first request
  task automatic t_reset();
    begin_prog();
    emit(8'hE0);
    repeat (2) @(negedge clk);
    check("R1 fault in reset", 64'(fault), 64'd0);
    rst_n = 1'b1;
    check("R1 first req", 64'(mem_req), 64'd1);
    check("R1 first addr", 64'(mem_addr), 64'd0);
    check("R1 first size", 64'(mem_size), 64'd0);
    check("R1 first we", 64'(mem_we), 64'd0);
    rst_n = 1'b0;
  endtask

  // R6 R7 R9 R3: constants of each size and store widths
  task automatic t_const_store();
    begin_prog();
    emit(8'h24); emit(8'h80);
    emit(8'h2C); emit(8'hF5);
    emit(8'h6B);
    emit(8'h35); emit_le(64'h90, 2);
    emit(8'h3E); emit_le(64'h12345678, 4);
    emit(8'h7D);
    emit(8'h34); emit(8'h08);
    emit(8'h2F); emit_le(64'h8000_0000_0000_0001, 8);
    emit(8'h6F);
    emit(8'h3D); emit_le(64'h8001, 2);
    emit(8'h34); emit(8'h08);
    emit(8'h7F);
    emit(8'hC3); emit(8'h43);
    emit(8'h34); emit(8'h08);
    emit(8'h6F);
    emit(8'hE0);
    run_to_halt("R7", 400);
    check("R7 8-bit const sext", rd64(8'h80), 64'hFFFF_FFFF_FFFF_FFF5);
    check("R9 16-bit store low", 64'({mem[8'h91], mem[8'h90]}), 64'h5678);
    check("R9 16-bit store width", 64'(mem[8'h92]), 64'h0);
    check("R7 64-bit const", rd64(8'h98), 64'h8000_0000_0000_0001);
    check("R7 16-bit const sext", rd64(8'hA0), 64'hFFFF_FFFF_FFFF_8001);
    check("R6 R3 addr const sext, zero-ext move", rd64(8'hA8), 64'h0000_0000_FFFF_FF80);
  endtask

  // R8: loads of several widths into both register kinds
  task automatic t_loads();
    begin_prog();
    for (int k = 0; k < 8; k++) mem[8'hC0 + k] = 8'(64'h9122334455667788 >> (8 * k));
    emit(8'h25); emit_le(64'hC0, 2);
    emit(8'h60);
    emit(8'h35); emit_le(64'hD0, 2);
    emit(8'h6F);
    emit(8'h72);
    emit(8'h34); emit(8'h08);
    emit(8'h7F);
    emit(8'h63);
    emit(8'h34); emit(8'h08);
    emit(8'h6F);
    emit(8'h39);
    emit(8'hD2); emit(8'h52);
    emit(8'h24); emit(8'h28);
    emit(8'h7B);
    emit(8'hE0);
    run_to_halt("R8", 400);
    check("R8 byte load sext", rd64(8'hD0), 64'hFFFF_FFFF_FFFF_FF88);
    check("R8 word load", rd64(8'hD8), 64'h0000_0000_5566_7788);
    check("R8 dword load", rd64(8'hE0), 64'h9122_3344_5566_7788);
    check("R8 addr reg load", rd64(8'hE8), 64'h7788);
  endtask

  // R10: all sixteen functions on one operand pair
  task automatic t_alu(input logic [7:0] x, input logic [7:0] y);
    logic [63:0] xa, yb;
    xa = {{56{x[7]}}, x};
    yb = {{56{y[7]}}, y};
    begin_prog();
    emit(8'h35); emit_le(64'h80, 2);
    emit(8'h2C); emit(x);
    emit(8'h3C); emit(y);
    emit(8'hA4);
    for (int f = 0; f < 16; f++) begin
      emit(8'h80 | 8'(f));
      emit(8'h6F);
      emit(8'h34); emit(8'h08);
      emit(8'h44);
    end
    emit(8'hE0);
    run_to_halt("R10", 2000);
    for (int f = 0; f < 16; f++)
      check($sformatf("R10 fn %0d", f), rd64(8'h80 + 8 * f), model_alu(f, xa, yb));
  endtask

  // R2 R4 R5: reading the counter, address shift, jump
  task automatic t_control();
    begin_prog();
    emit(8'h35); emit_le(64'h80, 2);
    emit(8'h4F);
    emit(8'h6F);
    emit(8'h24); emit(8'h05);
    emit(8'h23);
    emit(8'hC6); emit(8'h46);
    emit(8'h34); emit(8'h08);
    emit(8'h6F);
    emit(8'h3C); emit(8'h30);
    emit(8'hBF);
    while (wp < 8'h30) emit(8'hE0);
    emit(8'h2C); emit(8'h5A);
    emit(8'h34); emit(8'h08);
    emit(8'h6F);
    emit(8'hE0);
    run_to_halt("R4", 400);
    check("R2 counter read", rd64(8'h80), 64'd4);
    check("R5 address shift", rd64(8'h88), 64'd40);
    check("R4 jump target ran", rd64(8'h90), 64'h5A);
  endtask

  // R11: illegal syllables halt the core
  task automatic t_illegal(input logic [7:0] bad);
    int quiet;
    begin_prog();
    emit(8'h24); emit(8'h80);
    emit(8'h2C); emit(8'h11);
    emit(bad);
    emit(8'h6B);
    emit(8'hE0);
    run_to_halt("R11", 100);
    check($sformatf("R11 edges to fault %h", bad), 64'(ncyc), 64'd8);
    quiet = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (!mem_req && fault) quiet++;
    end
    check("R11 halted and silent", 64'(quiet), 64'd4);
    check("R11 later store skipped", rd64(8'h80), 64'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #1ns rst_n = 1'b0;
    t_reset();
    t_const_store();
    t_loads();
    t_alu(8'hFA, 8'h03);
    t_alu(8'h05, 8'h05);
    t_control();
    t_illegal(8'h27);
    t_illegal(8'h2B);
    t_illegal(8'hF3);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule